// File: doc/BRIEF.md
# NAND Sector Parity-Code Checker and Single-Bit Corrector

This block takes two parity codes for one flash sector: the code that was stored in the spare area when the sector was written, and the code computed over the data just read back. It XORs the two codes into a syndrome. It then sorts the result into one of four outcomes: clean, a correctable single-bit data error, an error in the stored code itself, or an uncorrectable error. For a correctable error it gives a page-relative byte address and a one-hot flip mask. An external sector buffer applies the fix by XORing that mask into the byte at that address.

A page may also be checked as a run of sub-blocks. One code pair is presented per sub-block, in order, with the first pair of a page flagged. Each result appears one register stage after its pair. A done pulse marks the last result of the page. The page ends early at the first sub-block that cannot be repaired. Later pairs of that page are then ignored until a new page is started. There is one special case: a stored code of all ones with a computed code of all zeros is the pattern an erased page gives, and it is treated as clean.

Top module: `eccchk_top`

## Requirements
- R1: Each code is CODE_W = 2*PAIRS bits, with PAIRS = 3 + log2(SECT_BYTES). Bit k of the low half is the even parity of address bit k, and bit PAIRS+k of the high half is the odd parity of address bit k. Address bits 0..2 select the bit within the byte and the higher address bits select the byte. The syndrome is the bitwise XOR of the two codes. When the two codes are equal, res_class is 0 (clean) and fix_strobe stays low.
- R2: A syndrome with exactly PAIRS ones is class 1 (correctable). The byte offset is taken from syndrome bits [CODE_W-1:PAIRS+3] and the bit index from bits [PAIRS+2:PAIRS]. fix_strobe is high, fix_mask is 1 shifted left by the bit index, and fix_addr is the sub-block index times SECT_BYTES plus the byte offset.
- R3: A syndrome with exactly one set bit is class 2 (error in the code).
- R4: Any other non-zero syndrome weight, including PAIRS-1, is class 3 (uncorrectable). This holds unless R5 applies.
- R5: A stored code of all ones together with a computed code of all zeros is class 0.
- R6: With page_mode high at the first pair, SUBS pairs make up one page. They are numbered 0..SUBS-1 in arrival order, and that number is reported on res_sub.
- R7: A result of class 2 or 3 ends the page: done pulses with that result. Further pairs without in_first produce no result until the next pair with in_first.
- R8: Each accepted pair gives res_valid exactly one cycle later. done pulses with the last sub-block's result, and in single mode (page_mode low) it pulses with the only result.
- R9: A pair presented without in_first while no page is in progress is ignored, and res_valid stays low.
- R10: After reset, res_valid, fix_strobe, done, fix_mask, fix_addr, res_class and res_sub are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A code pair is presented this cycle |
| in_first | input | 1 | This pair is the first sub-block of a page |
| page_mode | input | 1 | Sampled with in_first: 1 = SUBS sub-blocks, 0 = one sector |
| stored_code | input | CODE_W | Code read from the spare area |
| calc_code | input | CODE_W | Code computed over the data read back |
| res_valid | output | 1 | Result for the previous cycle's pair |
| res_class | output | 2 | 0 clean, 1 correctable, 2 code error, 3 uncorrectable |
| res_sub | output | IDX_W | Sub-block number of this result |
| fix_strobe | output | 1 | Apply fix_mask at fix_addr |
| fix_addr | output | IDX_W+OFF_W | Page-relative byte address to patch |
| fix_mask | output | 8 | One-hot bit to flip in that byte |
| done | output | 1 | Last result of the page |

## Verification
The bench builds the block with SECT_BYTES=16 and SUBS=4. This gives 14-bit codes, so every one of the 16384 possible syndromes can be swept and each outcome checked against a reference classification. The same small size allows all 128 single-bit data errors to be injected from their address geometry, all 14 single code-bit flips to be tried, and the erased-page pattern to be checked exactly. With four sub-blocks of 16 bytes, the address composition, the early end of a page after a failure, and the ignoring of stray pairs are all short, directed sequences.

// File: rtl/eccchk_pkg.sv
package eccchk_pkg;
  typedef enum logic [1:0] {
    CLS_CLEAN = 2'd0,
    CLS_FIX   = 2'd1,
    CLS_CODE  = 2'd2,
    CLS_LOST  = 2'd3
  } ecc_cls_t;
endpackage

// File: rtl/eccchk_classify.sv
module eccchk_classify
  import eccchk_pkg::*;
#(
  parameter int PAIRS = 12
) (
  input  logic [2*PAIRS-1:0] stored_code,
  input  logic [2*PAIRS-1:0] calc_code,
  output ecc_cls_t           cls,
  output logic [PAIRS-4:0]   byte_off,
  output logic [2:0]         bit_idx
);
  localparam int CODE_W = 2 * PAIRS;
  localparam int WT_W   = $clog2(CODE_W + 1);

  logic [CODE_W-1:0] syn;
  logic [WT_W-1:0]   weight;
  logic              erased;

  always_comb begin
    syn    = stored_code ^ calc_code;
    weight = '0;
    for (int k = 0; k < CODE_W; k++) begin
      weight = weight + WT_W'(syn[k]);
    end
    erased = (&stored_code) && !(|calc_code);
  end

  always_comb begin
    if (syn == '0 || erased)          cls = CLS_CLEAN;
    else if (weight == WT_W'(PAIRS))  cls = CLS_FIX;
    else if (weight == WT_W'(1))      cls = CLS_CODE;
    else                              cls = CLS_LOST;
  end

  assign byte_off = syn[CODE_W-1:PAIRS+3];
  assign bit_idx  = syn[PAIRS+2:PAIRS];
endmodule

// File: rtl/eccchk_seq.sv
module eccchk_seq #(
  parameter int SUBS  = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             page_mode,
  input  logic             fail,
  output logic             accept,
  output logic [IDX_W-1:0] idx,
  output logic             finish
);
  logic             act_q, act_d;
  logic             mode_q, mode_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             multi, last;

  always_comb begin
    accept = in_valid && (in_first || act_q);
    idx    = in_first ? '0 : cnt_q;
    multi  = in_first ? page_mode : mode_q;
    last   = multi ? (idx == IDX_W'(SUBS - 1)) : 1'b1;
    finish = accept && (last || fail);
    act_d  = act_q;
    cnt_d  = cnt_q;
    mode_d = mode_q;
    if (accept) begin
      act_d = !finish;
      cnt_d = idx + IDX_W'(1);
    end
    if (in_valid && in_first) begin
      mode_d = page_mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      mode_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      act_q  <= act_d;
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/eccchk_top.sv
module eccchk_top
  import eccchk_pkg::*;
#(
  parameter int SECT_BYTES = 512,
  parameter int SUBS       = 4,
  localparam int OFF_W  = $clog2(SECT_BYTES),
  localparam int PAIRS  = 3 + OFF_W,
  localparam int CODE_W = 2 * PAIRS,
  localparam int IDX_W  = (SUBS > 1) ? $clog2(SUBS) : 1,
  localparam int ADDR_W = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic              page_mode,
  input  logic [CODE_W-1:0] stored_code,
  input  logic [CODE_W-1:0] calc_code,
  output logic              res_valid,
  output logic [1:0]        res_class,
  output logic [IDX_W-1:0]  res_sub,
  output logic              fix_strobe,
  output logic [ADDR_W-1:0] fix_addr,
  output logic [7:0]        fix_mask,
  output logic              done
);
  ecc_cls_t         cls;
  logic [OFF_W-1:0] byte_off;
  logic [2:0]       bit_idx;
  logic             fail, accept, finish;
  logic [IDX_W-1:0] idx;
  logic             is_fix;

  eccchk_classify #(.PAIRS(PAIRS)) u_cls (
    .stored_code (stored_code),
    .calc_code   (calc_code),
    .cls         (cls),
    .byte_off    (byte_off),
    .bit_idx     (bit_idx)
  );

  assign fail = (cls == CLS_CODE) || (cls == CLS_LOST);

  eccchk_seq #(.SUBS(SUBS), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_first  (in_first),
    .page_mode (page_mode),
    .fail      (fail),
    .accept    (accept),
    .idx       (idx),
    .finish    (finish)
  );

  logic              valid_d, strobe_d, done_d;
  logic [1:0]        class_d;
  logic [IDX_W-1:0]  sub_d;
  logic [ADDR_W-1:0] addr_d;
  logic [7:0]        mask_d;

  always_comb begin
    is_fix   = accept && (cls == CLS_FIX);
    valid_d  = accept;
    done_d   = finish;
    strobe_d = is_fix;
    class_d  = accept ? 2'(cls) : 2'd0;
    sub_d    = accept ? idx : '0;
    addr_d   = is_fix ? {idx, byte_off} : '0;
    mask_d   = is_fix ? (8'd1 << bit_idx) : 8'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_class  <= 2'd0;
      res_sub    <= '0;
      fix_strobe <= 1'b0;
      fix_addr   <= '0;
      fix_mask   <= 8'd0;
      done       <= 1'b0;
    end else begin
      res_valid  <= valid_d;
      res_class  <= class_d;
      res_sub    <= sub_d;
      fix_strobe <= strobe_d;
      fix_addr   <= addr_d;
      fix_mask   <= mask_d;
      done       <= done_d;
    end
  end
endmodule

// File: rtl/eccchk_sva.sv
module eccchk_sva #(
  parameter int CODE_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_first,
  input logic [CODE_W-1:0] stored_code,
  input logic [CODE_W-1:0] calc_code,
  input logic              res_valid,
  input logic [1:0]        res_class,
  input logic              fix_strobe,
  input logic [7:0]        fix_mask,
  input logic              done
);
  AST_SAME_IS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first && stored_code == calc_code) |=> (res_valid && res_class == 2'd0 && !fix_strobe)); // R1
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    fix_strobe |-> (res_valid && res_class == 2'd1 && $countones(fix_mask) == 1)); // R2
  AST_FAIL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_class[1]) |-> done); // R7
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid)); // R8
  AST_DONE_HAS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> res_valid); // R8
  AST_NO_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !fix_strobe |-> (fix_mask == 8'd0)); // R10
endmodule

bind eccchk_top eccchk_sva #(.CODE_W(CODE_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_first    (in_first),
  .stored_code (stored_code),
  .calc_code   (calc_code),
  .res_valid   (res_valid),
  .res_class   (res_class),
  .fix_strobe  (fix_strobe),
  .fix_mask    (fix_mask),
  .done        (done)
);

// File: tb/tb_eccchk_top.sv
`timescale 1ns/1ps
module tb_eccchk_top;
  localparam int SB = 16;
  localparam int NS = 4;
  localparam int PR = 7;
  localparam int CW = 14;

  logic clk, rst_n, in_valid, in_first, page_mode;
  logic [CW-1:0] stored_code, calc_code;
  logic res_valid, fix_strobe, done;
  logic [1:0] res_class, res_sub;
  logic [5:0] fix_addr;
  logic [7:0] fix_mask;
  int total = 0, bad = 0;

  eccchk_top #(.SECT_BYTES(SB), .SUBS(NS)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .page_mode(page_mode), .stored_code(stored_code), .calc_code(calc_code),
    .res_valid(res_valid), .res_class(res_class), .res_sub(res_sub),
    .fix_strobe(fix_strobe), .fix_addr(fix_addr), .fix_mask(fix_mask), .done(done));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [1:0] ref_class(input logic [CW-1:0] st, input logic [CW-1:0] ca);
    logic [CW-1:0] s;
    int w;
    s = st ^ ca;
    w = $countones(s);
    if (s == '0 || (st == '1 && ca == '0)) return 2'd0;
    if (w == PR) return 2'd1;
    if (w == 1) return 2'd2;
    return 2'd3;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic present(input logic first, input logic mode, input logic [CW-1:0] st, input logic [CW-1:0] ca);
    @(negedge clk);
    in_valid = 1'b1; in_first = first; page_mode = mode;
    stored_code = st; calc_code = ca;
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0;
  endtask

  function automatic logic [CW-1:0] data_err(input int addr);
    logic [PR-1:0] a;
    a = PR'(addr);
    return {a, ~a};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [CW-1:0] st, s;
    logic [1:0] ec;
    rst_n = 1'b0; in_valid = 1'b0; in_first = 1'b0; page_mode = 1'b0;
    stored_code = '0; calc_code = '0;
    repeat (3) @(negedge clk);
    check("R10 reset outputs", {res_valid, fix_strobe, done, res_class, res_sub, fix_addr, fix_mask},
          32'd0);
    rst_n = 1'b1;

    // R1 equal codes clean
    present(1'b1, 1'b0, 14'h2A5C, 14'h2A5C);
    check("R1 equal clean", {res_valid, res_class, fix_strobe, done}, {1'b1, 2'd0, 1'b0, 1'b1});

    // R2 every single data-bit error from geometry
    for (int a = 0; a < SB * 8; a++) begin
      st = 14'(a * 91 + 5);
      present(1'b1, 1'b0, st, st ^ data_err(a));
      check("R2 data bit fix", {res_class, fix_strobe, fix_addr, fix_mask},
            {2'd1, 1'b1, 6'(a >> 3), 8'd1 << (a % 8)});
    end

    // R3 every single code-bit flip
    for (int j = 0; j < CW; j++) begin
      present(1'b1, 1'b0, 14'h1234, 14'h1234 ^ (14'd1 << j));
      check("R3 code bit", {res_class, fix_strobe, done}, {2'd2, 1'b0, 1'b1});
    end

    // R5 erased page and near-erased
    present(1'b1, 1'b0, '1, '0);
    check("R5 erased clean", {res_class, fix_strobe}, {2'd0, 1'b0});
    present(1'b1, 1'b0, '1, 14'd1);
    check("R4 near-erased lost", res_class, 2'd3);

    // R4 exhaustive syndrome sweep, single mode, R8 done each time
    for (int i = 0; i < (1 << CW); i++) begin
      s  = CW'(i);
      st = CW'(i * 7 + 3);
      ec = ref_class(st, st ^ s);
      present(1'b1, 1'b0, st, st ^ s);
      check("R4 sweep class", {res_valid, done, res_class, fix_strobe,
                               (ec == 2'd1) ? {s[CW-1:PR+3], 2'b00} : 6'd0,
                               fix_addr},
            {1'b1, 1'b1, ec, ec == 2'd1, (ec == 2'd1) ? {s[CW-1:PR+3], 2'b00} : 6'd0,
             (ec == 2'd1) ? {2'b00, s[CW-1:PR+3]} : 6'd0});
    end

    // R6 four sub-blocks, fixes in sub1 and sub3
    present(1'b1, 1'b1, 14'h0F0F, 14'h0F0F);
    check("R6 sub0", {res_valid, res_sub, done}, {1'b1, 2'd0, 1'b0});
    present(1'b0, 1'b0, 14'h0100, 14'h0100 ^ data_err(5 * 8 + 3));
    check("R6 sub1 addr", {res_sub, res_class, fix_addr, fix_mask, done},
          {2'd1, 2'd1, 6'(16 + 5), 8'h08, 1'b0});
    present(1'b0, 1'b0, 14'h0002, 14'h0002);
    check("R6 sub2", {res_valid, res_sub, done}, {1'b1, 2'd2, 1'b0});
    present(1'b0, 1'b0, 14'h3001, 14'h3001 ^ data_err(15 * 8 + 7));
    check("R8 sub3 done", {res_sub, fix_addr, fix_mask, done}, {2'd3, 6'd63, 8'h80, 1'b1});
    present(1'b0, 1'b0, 14'h0, 14'h3);
    check("R9 stray pair", {res_valid, done}, 2'b00);

    // R7 page ends at uncorrectable sub1
    present(1'b1, 1'b1, 14'h0777, 14'h0777);
    check("R7 sub0", {res_valid, done}, 2'b10);
    present(1'b0, 1'b0, 14'h0777, 14'h0774);
    check("R7 fail ends", {res_valid, res_sub, res_class, done}, {1'b1, 2'd1, 2'd3, 1'b1});
    present(1'b0, 1'b0, 14'h0, 14'h0);
    check("R7 ignored after fail", {res_valid, done, fix_strobe}, 3'b000);
    present(1'b1, 1'b1, 14'h0, 14'h0);
    check("R7 restart", {res_valid, res_sub, done}, {1'b1, 2'd0, 1'b0});
    present(1'b0, 1'b0, 14'h0, 14'h1);
    check("R7 code err ends", {res_class, res_sub, done}, {2'd2, 2'd1, 1'b1});

    // R8 idle cycle after result
    @(negedge clk);
    check("R8 one cycle only", {res_valid, done, fix_strobe}, 3'b000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule